// File: doc/BRIEF.md
# Nonlinear PI Voltage Regulator

This block closes the output-voltage loop of a power converter. Each time a new voltage sample arrives, it forms the signed error between a reference and the sample, then applies a proportional-integral law whose gains depend on the size of that error. A large error selects a stronger proportional gain, so transients recover faster. A large error also selects a weaker integral gain, which limits integrator build-up and overshoot. The integrator is held between programmable bounds, and the control word is saturated to its signed width.

The integrator is cleared once after the mains supply comes back. A rising edge on the AC-present flag arms a one-shot reset. The first sample after that edge whose error magnitude lies within a programmable band around zero sets the integrator to zero. This discards the windup built up while the supply was absent.

A four-state machine sequences each sample:
- IDLE waits for a valid sample and captures the error (IDLE→PROD on a valid sample).
- PROD registers the gain products and the clear decision (PROD→INTEG, always).
- INTEG updates the integrator (INTEG→EMIT, always).
- EMIT registers the saturated output and pulses valid (EMIT→IDLE, always).

Top module: `npi_volt_reg`

## Requirements
- R1: The error is e = v_ref − v_meas as a signed value. The control word is floor(Kp·e / 2^FRAC) + floor(I / 2^FRAC), where I is the integrator after the current sample's update. Gains are unsigned with FRAC fractional bits.
- R2: Kp is kp_hi when |e| is strictly greater than kp_thr, and kp_lo otherwise.
- R3: Ki is ki_lo when |e| is strictly greater than ki_thr, and ki_hi otherwise.
- R4: Each accepted sample adds Ki·e to the integrator and clamps the result to [int_lo, int_hi].
- R5: The control word saturates to the signed OW-bit range, from −2^(OW−1) to 2^(OW−1)−1.
- R6: A rising edge of ac_ok arms a one-shot reset. The next sample with |e| ≤ reg_band sets the integrator to zero instead of accumulating, and disarms the reset. Later samples accumulate normally until ac_ok rises again.
- R7: While ac_ok is low the reset is disarmed. A rise followed by a fall therefore clears nothing.
- R8: ctrl_vld is a one-cycle pulse, seen in the cycle after the fourth rising clock edge, counting the edge that accepts the sample as the first. A valid sample that arrives while the machine is not in IDLE is ignored.
- R9: After reset, ctrl_out is 0, ctrl_vld is 0 and the integrator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| v_ref | input | DW | Voltage reference, unsigned |
| v_meas | input | DW | Measured output voltage, unsigned |
| v_meas_vld | input | 1 | v_meas holds a new sample |
| ac_ok | input | 1 | Mains present |
| kp_lo | input | GW | Proportional gain for small errors |
| kp_hi | input | GW | Proportional gain for large errors |
| kp_thr | input | DW | Error magnitude above which kp_hi applies |
| ki_lo | input | GW | Integral gain for large errors |
| ki_hi | input | GW | Integral gain for small errors |
| ki_thr | input | DW | Error magnitude above which ki_lo applies |
| int_lo | input | IW | Integrator lower bound, signed |
| int_hi | input | IW | Integrator upper bound, signed |
| reg_band | input | DW | Error magnitude treated as in regulation |
| ctrl_out | output | OW | Control word, signed |
| ctrl_vld | output | 1 | One-cycle pulse marking a new control word |

## Verification
The control word and its valid pulse appear after the fourth rising edge, counting the edge that accepts the sample. The bench drives inputs on falling edges and counts falling edges after the drive. It requires valid low at the first three falling edges, then valid high with the predicted word at the fourth, then low again at the fifth. A change of ac_ok reaches the arm state one edge later, so the bench waits a few cycles before the next sample. The extra sample used to test that busy samples are ignored is placed inside the busy window, and its effect is judged from the following output.

// File: rtl/npi_pkg.sv
package npi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROD  = 2'd1,
        ST_INTEG = 2'd2,
        ST_EMIT  = 2'd3
    } npi_state_e;

endpackage

// File: rtl/npi_gain_sel.sv
module npi_gain_sel #(
    parameter int DW = 16,
    parameter int GW = 16,
    localparam int EW = DW + 1
) (
    input  logic signed [EW-1:0] err,
    input  logic        [DW-1:0] kp_thr,
    input  logic        [DW-1:0] ki_thr,
    input  logic        [GW-1:0] kp_lo,
    input  logic        [GW-1:0] kp_hi,
    input  logic        [GW-1:0] ki_lo,
    input  logic        [GW-1:0] ki_hi,
    output logic        [EW-1:0] mag,
    output logic        [GW-1:0] kp_sel,
    output logic        [GW-1:0] ki_sel
);

    always_comb begin
        if (err[EW-1]) begin
            mag = $unsigned(-err);
        end else begin
            mag = $unsigned(err);
        end
    end

    // strong proportional action on large excursions
    always_comb begin
        if (mag > {1'b0, kp_thr}) begin
            kp_sel = kp_hi;
        end else begin
            kp_sel = kp_lo;
        end
    end

    // weak integral action on large excursions
    always_comb begin
        if (mag > {1'b0, ki_thr}) begin
            ki_sel = ki_lo;
        end else begin
            ki_sel = ki_hi;
        end
    end

endmodule

// File: rtl/npi_rearm.sv
module npi_rearm #(
    parameter int DW = 16,
    localparam int EW = DW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ac_ok,
    input  logic          eval,
    input  logic [EW-1:0] mag,
    input  logic [DW-1:0] band,
    output logic          clr
);

    logic ac_d;
    logic armed_q;
    logic rise;

    assign rise = ac_ok & ~ac_d;
    assign clr  = armed_q & ac_ok & eval & (mag <= {1'b0, band});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_d    <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ac_d <= ac_ok;
            if (!ac_ok) begin
                armed_q <= 1'b0;
            end else if (rise) begin
                armed_q <= 1'b1;
            end else if (clr) begin
                armed_q <= 1'b0;
            end
        end
    end

    AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ac_ok) |=> armed_q); // R6
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !armed_q); // R6
    AST_DROP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        !ac_ok |=> !armed_q); // R7

endmodule

// File: rtl/npi_integrator.sv
module npi_integrator #(
    parameter int PW = 34,
    parameter int IW = 32,
    localparam int SW = ((PW > IW) ? PW : IW) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic                 clr,
    input  logic signed [PW-1:0] inc,
    input  logic signed [IW-1:0] lo,
    input  logic signed [IW-1:0] hi,
    output logic signed [IW-1:0] acc
);

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] lim;

    assign sum = SW'(acc) + SW'(inc);

    always_comb begin
        if (sum > SW'(hi)) begin
            lim = SW'(hi);
        end else if (sum < SW'(lo)) begin
            lim = SW'(lo);
        end else begin
            lim = sum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (upd) begin
            if (clr) begin
                acc <= '0;
            end else begin
                acc <= IW'(lim);
            end
        end
    end

    AST_INT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !clr) |=> (acc >= lo && acc <= hi)); // R4
    AST_INT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && clr) |=> (acc == '0)); // R6

endmodule

// File: rtl/npi_volt_reg.sv
module npi_volt_reg #(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 8,
    parameter int IW   = 32,
    parameter int OW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic        [DW-1:0] v_ref,
    input  logic        [DW-1:0] v_meas,
    input  logic                 v_meas_vld,
    input  logic                 ac_ok,
    input  logic        [GW-1:0] kp_lo,
    input  logic        [GW-1:0] kp_hi,
    input  logic        [DW-1:0] kp_thr,
    input  logic        [GW-1:0] ki_lo,
    input  logic        [GW-1:0] ki_hi,
    input  logic        [DW-1:0] ki_thr,
    input  logic signed [IW-1:0] int_lo,
    input  logic signed [IW-1:0] int_hi,
    input  logic        [DW-1:0] reg_band,
    output logic signed [OW-1:0] ctrl_out,
    output logic                 ctrl_vld
);
    import npi_pkg::*;

    localparam int EW = DW + 1;
    localparam int PW = EW + GW + 1;
    localparam int SW = ((PW > IW) ? PW : IW) + 1;
    localparam logic signed [SW-1:0] OMAX = SW'((64'sd1 <<< (OW - 1)) - 64'sd1);
    localparam logic signed [SW-1:0] OMIN = SW'(-(64'sd1 <<< (OW - 1)));

    npi_state_e state_q, state_d;

    logic                 accept;
    logic signed [EW-1:0] err_c, err_q;
    logic        [EW-1:0] mag;
    logic        [GW-1:0] kp_sel, ki_sel;
    logic signed [PW-1:0] p_c, i_c, p_q, i_q;
    logic                 clr_c, clr_q;
    logic signed [IW-1:0] acc;
    logic signed [SW-1:0] sum_c;
    logic signed [OW-1:0] sat_c;

    assign accept = (state_q == ST_IDLE) && v_meas_vld;
    assign err_c  = $signed({1'b0, v_ref}) - $signed({1'b0, v_meas});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (v_meas_vld) state_d = ST_PROD;
            ST_PROD:  state_d = ST_INTEG;
            ST_INTEG: state_d = ST_EMIT;
            ST_EMIT:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (accept) begin
            err_q <= err_c;
        end
    end

    npi_gain_sel #(.DW(DW), .GW(GW)) u_gain (
        .err    (err_q),
        .kp_thr (kp_thr),
        .ki_thr (ki_thr),
        .kp_lo  (kp_lo),
        .kp_hi  (kp_hi),
        .ki_lo  (ki_lo),
        .ki_hi  (ki_hi),
        .mag    (mag),
        .kp_sel (kp_sel),
        .ki_sel (ki_sel)
    );

    npi_rearm #(.DW(DW)) u_rearm (
        .clk   (clk),
        .rst_n (rst_n),
        .ac_ok (ac_ok),
        .eval  (state_q == ST_PROD),
        .mag   (mag),
        .band  (reg_band),
        .clr   (clr_c)
    );

    assign p_c = PW'($signed({1'b0, kp_sel})) * PW'(err_q);
    assign i_c = PW'($signed({1'b0, ki_sel})) * PW'(err_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q   <= '0;
            i_q   <= '0;
            clr_q <= 1'b0;
        end else if (state_q == ST_PROD) begin
            p_q   <= p_c;
            i_q   <= i_c;
            clr_q <= clr_c;
        end
    end

    npi_integrator #(.PW(PW), .IW(IW)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (state_q == ST_INTEG),
        .clr   (clr_q),
        .inc   (i_q),
        .lo    (int_lo),
        .hi    (int_hi),
        .acc   (acc)
    );

    assign sum_c = SW'(p_q >>> FRAC) + SW'(acc >>> FRAC);

    always_comb begin
        if (sum_c > OMAX) begin
            sat_c = OW'(OMAX);
        end else if (sum_c < OMIN) begin
            sat_c = OW'(OMIN);
        end else begin
            sat_c = OW'(sum_c);
        end
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_out <= '0;
            ctrl_vld <= 1'b0;
        end else begin
            ctrl_vld <= (state_q == ST_EMIT);
            if (state_q == ST_EMIT) begin
                ctrl_out <= sat_c;
            end
        end
    end

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_vld |=> !ctrl_vld); // R8
    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_vld |-> $past(accept, 4)); // R8
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(err_q)); // R8

endmodule

// File: tb/npi_volt_reg_bench.sv
module npi_volt_reg_bench;

    localparam int DW = 16, GW = 16, FRAC = 8, IW = 32, OW = 16;
    localparam longint OMAXL = (64'sd1 <<< (OW - 1)) - 1;
    localparam longint OMINL = -(64'sd1 <<< (OW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] v_ref = '0, v_meas = '0, kp_thr, ki_thr, reg_band;
    logic v_meas_vld = 1'b0, ac_ok = 1'b0;
    logic [GW-1:0] kp_lo, kp_hi, ki_lo, ki_hi;
    logic signed [IW-1:0] int_lo, int_hi;
    logic signed [OW-1:0] ctrl_out;
    logic ctrl_vld;

    int checks = 0, failures = 0;
    longint m_acc = 0;
    bit m_armed = 0, m_ac = 0;

    always #4 clk = ~clk;

    npi_volt_reg #(.DW(DW), .GW(GW), .FRAC(FRAC), .IW(IW), .OW(OW)) u_npi_volt_reg (
        .clk(clk), .rst_n(rst_n), .v_ref(v_ref), .v_meas(v_meas),
        .v_meas_vld(v_meas_vld), .ac_ok(ac_ok), .kp_lo(kp_lo), .kp_hi(kp_hi),
        .kp_thr(kp_thr), .ki_lo(ki_lo), .ki_hi(ki_hi), .ki_thr(ki_thr),
        .int_lo(int_lo), .int_hi(int_hi), .reg_band(reg_band),
        .ctrl_out(ctrl_out), .ctrl_vld(ctrl_vld)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_ac(input bit v);
        @(negedge clk);
        ac_ok = v;
        if (v && !m_ac) m_armed = 1;
        if (!v) m_armed = 0;
        m_ac = v;
        repeat (3) @(negedge clk);
    endtask

    // one sample; optional extra valid inside the busy window
    task automatic run_sample(input string req, input int rf, input int ms, input bit extra);
        longint e, mg, kp, ki, p, u;
        e  = longint'(rf) - longint'(ms);
        mg = (e < 0) ? -e : e;
        kp = (mg > longint'(kp_thr)) ? longint'(kp_hi) : longint'(kp_lo);   // R2
        ki = (mg > longint'(ki_thr)) ? longint'(ki_lo) : longint'(ki_hi);   // R3
        if (m_armed && m_ac && mg <= longint'(reg_band)) begin              // R6
            m_acc = 0;
            m_armed = 0;
        end else begin                                                      // R4
            m_acc = m_acc + ki * e;
            if (m_acc > longint'(int_hi)) m_acc = longint'(int_hi);
            if (m_acc < longint'(int_lo)) m_acc = longint'(int_lo);
        end
        p = kp * e;
        u = (p >>> FRAC) + (m_acc >>> FRAC);                                // R1
        if (u > OMAXL) u = OMAXL;                                           // R5
        if (u < OMINL) u = OMINL;
        @(negedge clk);
        v_ref = DW'(rf); v_meas = DW'(ms); v_meas_vld = 1'b1;
        @(negedge clk);
        v_meas_vld = 1'b0;
        chk({req, " R8 vld@1"}, longint'(ctrl_vld), 0);
        if (extra) begin
            v_meas = DW'(ms + 4000); v_meas_vld = 1'b1;
        end
        @(negedge clk);
        v_meas_vld = 1'b0;
        chk({req, " R8 vld@2"}, longint'(ctrl_vld), 0);
        @(negedge clk);
        chk({req, " R8 vld@3"}, longint'(ctrl_vld), 0);
        @(negedge clk);
        chk({req, " R8 vld@4"}, longint'(ctrl_vld), 1);
        chk({req, " out"}, longint'(ctrl_out), u);
        @(negedge clk);
        chk({req, " R8 vld@5"}, longint'(ctrl_vld), 0);
    endtask

    task automatic t_reset();
        chk("R9 out after reset", longint'(ctrl_out), 0);
        chk("R9 vld after reset", longint'(ctrl_vld), 0);
        run_sample("R9 first sample from zero integrator", 1000, 1000, 0);
    endtask

    task automatic t_basic();
        run_sample("R1 small positive", 1010, 1000, 0);
        run_sample("R1 small negative", 990, 1000, 0);
        run_sample("R2 R3 large positive", 1300, 1000, 0);
        run_sample("R2 R3 large negative", 700, 1000, 0);
    endtask

    task automatic t_thresholds();
        run_sample("R2 at kp_thr", 1100, 1000, 0);
        run_sample("R2 above kp_thr", 1101, 1000, 0);
        run_sample("R3 at ki_thr", 950, 1000, 0);
        run_sample("R3 above ki_thr", 949, 1000, 0);
    endtask

    task automatic t_clamp();
        @(negedge clk);
        int_hi = 3000; int_lo = -2500;
        for (int i = 0; i < 4; i++) run_sample("R4 upper clamp", 1040, 1000, 0);
        for (int i = 0; i < 6; i++) run_sample("R4 lower clamp", 960, 1000, 0);
        @(negedge clk);
        int_hi = 200000; int_lo = -200000;
    endtask

    task automatic t_saturate();
        run_sample("R5 positive saturation", 40000, 10000, 0);
        run_sample("R5 negative saturation", 10000, 40000, 0);
    endtask

    task automatic t_rearm();
        run_sample("R6 build", 1040, 1000, 0);
        set_ac(0);
        set_ac(1);
        run_sample("R6 outside band no clear", 1020, 1000, 0);
        run_sample("R6 inside band clears", 1003, 1000, 0);
        run_sample("R6 second in band no clear", 1002, 1000, 0);
    endtask

    task automatic t_disarm();
        run_sample("R7 build", 1030, 1000, 0);
        set_ac(0);
        set_ac(1);
        set_ac(0);
        run_sample("R7 in band after drop", 1001, 1000, 0);
        set_ac(1);
        run_sample("R7 clear after fresh rise", 999, 1000, 0);
    endtask

    task automatic t_busy();
        run_sample("R8 extra sample while busy", 1025, 1000, 1);
        run_sample("R8 next sample unaffected", 1015, 1000, 0);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        kp_lo = 256; kp_hi = 1024; kp_thr = 100;
        ki_lo = 16;  ki_hi = 64;   ki_thr = 50;
        int_lo = -200000; int_hi = 200000; reg_band = 5;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_thresholds();
        t_clamp();
        t_saturate();
        t_rearm();
        t_disarm();
        t_busy();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule